// File: doc/BRIEF.md
# x86-64 Operand Addressing Decoder

This block turns the addressing bytes of one x86-64 instruction into a decoded operand description. The inputs are the REX prefix bits together with a flag that says whether a REX prefix was seen, the ModRM byte, the SIB byte and four raw displacement bytes. The outputs describe the operands. They give the register-operand number and say whether the second operand is a register or a memory reference. For a memory reference they give the base and index register numbers, the scale multiplier and a sign-extended 64-bit displacement. Flags mark a missing base, a missing index and RIP-relative addressing. The ModRM and SIB bytes are split into fields, the REX extension bits are applied, and the special field codes that remove the base or the index are recognised.

An upstream length decoder presents the bytes it has collected and raises `in_valid` for one cycle. One cycle later the decoded result appears, and `out_valid` is high for that single cycle. The result registers then keep their values until the next strobe, so downstream address logic can read them at any later time. For 8-bit operand instructions, the block also reports when a register code names one of the legacy high-byte registers.

Top module: `opaddr_decode`

## Requirements
- R1: A result is registered on the clock edge where `in_valid` is high. `out_valid` is high for exactly the following cycle. While `in_valid` stays low, every result output keeps its value.
- R2: `reg_num` equals {REX.R, ModRM[5:3]}. REX.R, REX.X and REX.B count only when `rex_present` is 1. Otherwise they are treated as 0.
- R3: When ModRM[7:6] is 11, `rm_is_reg` is 1 and `rm_reg` equals {REX.B, ModRM[2:0]}. In the same case `no_base` and `no_index` are 1, `has_sib` is 0 and `disp` is 0.
- R4: For a memory operand where ModRM[2:0] is not 100 and it is not the R5 case, `base_num` equals {REX.B, ModRM[2:0]}. In that case `no_index` is 1, `has_sib` is 0 and `scale_mul` is 1.
- R5: When ModRM[7:6] is 00 and ModRM[2:0] is 101, `rip_rel` and `no_base` are 1, and `disp` is the 32-bit displacement sign-extended to 64 bits.
- R6: A memory operand with ModRM[2:0] = 100 uses the SIB byte, and `has_sib` is 1. SIB[7:6] codes 00, 01, 10 and 11 give a `scale_mul` of 1, 2, 4 and 8. The index is {REX.X, SIB[5:3]} and the base is {REX.B, SIB[2:0]}.
- R7: There is no index register (`no_index` = 1, `index_num` = 0) only when the extended index {REX.X, SIB[5:3]} is 0100. With REX.X = 1 the same field code selects register 12.
- R8: SIB base code 101 with ModRM[7:6] = 00 sets `no_base` (`base_num` = 0) and uses a 32-bit displacement, whatever REX.B is. With mod 01 or 10 the same code names register 5, or register 13 when REX.B = 1.
- R9: The displacement bytes are taken little-endian: `disp_in[7:0]` is the first and least significant byte. With mod 01 the low byte is sign-extended. With mod 10 all four bytes are sign-extended. With mod 00, `disp` is 0 except in the R5 and R8 cases.
- R10: When `byte_op` is 1 and no REX prefix is present, a register code from 4 to 7 (in `reg_num` or in a register `rm_reg`) raises the matching `*_hi8` flag and is reported as code minus 4: 4 is AH, reported as 0 with the flag set. When a REX prefix is present, codes 4 to 7 stay as they are with the flag clear (SPL, BPL, SIL, DIL).
- R11: After reset, `out_valid` and every result output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: input bytes are valid |
| rex_present | input | 1 | A REX prefix was captured |
| rex_r | input | 1 | REX.R bit |
| rex_x | input | 1 | REX.X bit |
| rex_b | input | 1 | REX.B bit |
| byte_op | input | 1 | Instruction has 8-bit operands |
| modrm | input | 8 | ModRM byte |
| sib | input | 8 | SIB byte (ignored when not used) |
| disp_in | input | 32 | Displacement bytes, first byte in bits 7:0 |
| out_valid | output | 1 | One-cycle result strobe |
| reg_num | output | 4 | Register-operand number |
| reg_hi8 | output | 1 | `reg_num` names a high-byte register |
| rm_is_reg | output | 1 | Second operand is a register |
| rm_reg | output | 4 | Second-operand register number when `rm_is_reg` |
| rm_hi8 | output | 1 | `rm_reg` names a high-byte register |
| has_sib | output | 1 | SIB byte was used |
| base_num | output | 4 | Base register number |
| index_num | output | 4 | Index register number |
| scale_mul | output | 4 | Index multiplier: 1, 2, 4 or 8 |
| disp | output | 64 | Sign-extended displacement |
| no_base | output | 1 | No base register |
| no_index | output | 1 | No index register |
| rip_rel | output | 1 | RIP-relative addressing |

## Verification
The assertions assume that `rst_n` is low from time zero and that input bytes are meaningful only in a cycle where `in_valid` is high. The displacement sign check is made one cycle after such a strobe. The bench changes its inputs only on falling edges and keeps each strobe to a single cycle. Between strobes it sets the inputs to unrelated values, which exercises the hold behaviour without breaking the assumed input protocol.

// File: rtl/opaddr_decode.sv
module opaddr_decode (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        rex_present,
  input  logic        rex_r,
  input  logic        rex_x,
  input  logic        rex_b,
  input  logic        byte_op,
  input  logic [7:0]  modrm,
  input  logic [7:0]  sib,
  input  logic [31:0] disp_in,
  output logic        out_valid,
  output logic [3:0]  reg_num,
  output logic        reg_hi8,
  output logic        rm_is_reg,
  output logic [3:0]  rm_reg,
  output logic        rm_hi8,
  output logic        has_sib,
  output logic [3:0]  base_num,
  output logic [3:0]  index_num,
  output logic [3:0]  scale_mul,
  output logic [63:0] disp,
  output logic        no_base,
  output logic        no_index,
  output logic        rip_rel
);

  wire [1:0] md    = modrm[7:6];
  wire [2:0] rg    = modrm[5:3];
  wire [2:0] rmf   = modrm[2:0];
  wire [1:0] sc    = sib[7:6];
  wire [2:0] ix    = sib[5:3];
  wire [2:0] bs    = sib[2:0];

  wire ext_r = rex_present & rex_r;
  wire ext_x = rex_present & rex_x;
  wire ext_b = rex_present & rex_b;

  wire is_reg  = (md == 2'b11);
  wire use_sib = !is_reg && (rmf == 3'b100);
  wire rip     = (md == 2'b00) && (rmf == 3'b101);
  wire sib_nob = use_sib && (md == 2'b00) && (bs == 3'b101);
  wire [3:0] ix_full = {ext_x, ix};
  wire sib_nix = (ix_full == 4'b0100);

  wire legacy8 = byte_op && !rex_present;
  wire rg_hi   = legacy8 && rg[2];
  wire rm_hi   = legacy8 && is_reg && rmf[2];

  wire [63:0] d8  = {{56{disp_in[7]}}, disp_in[7:0]};
  wire [63:0] d32 = {{32{disp_in[31]}}, disp_in};

  logic [63:0] disp_n;
  logic [3:0]  base_n, index_n, scale_n, rmreg_n;
  logic        nob_n, noix_n;

  always_comb begin
    case (md)
      2'b01:   disp_n = d8;
      2'b10:   disp_n = d32;
      2'b00:   disp_n = (rip || sib_nob) ? d32 : 64'd0;
      default: disp_n = 64'd0;
    endcase
  end

  always_comb begin
    base_n  = 4'd0;
    index_n = 4'd0;
    scale_n = 4'd1;
    rmreg_n = 4'd0;
    nob_n   = 1'b1;
    noix_n  = 1'b1;
    if (is_reg) begin
      rmreg_n = rm_hi ? {2'b00, rmf[1:0]} : {ext_b, rmf};
    end else if (use_sib) begin
      scale_n = 4'd1 << sc;
      noix_n  = sib_nix;
      index_n = sib_nix ? 4'd0 : ix_full;
      nob_n   = sib_nob;
      base_n  = sib_nob ? 4'd0 : {ext_b, bs};
    end else if (!rip) begin
      nob_n  = 1'b0;
      base_n = {ext_b, rmf};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      reg_num   <= 4'd0;
      reg_hi8   <= 1'b0;
      rm_is_reg <= 1'b0;
      rm_reg    <= 4'd0;
      rm_hi8    <= 1'b0;
      has_sib   <= 1'b0;
      base_num  <= 4'd0;
      index_num <= 4'd0;
      scale_mul <= 4'd0;
      disp      <= 64'd0;
      no_base   <= 1'b0;
      no_index  <= 1'b0;
      rip_rel   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        reg_num   <= rg_hi ? {2'b00, rg[1:0]} : {ext_r, rg};
        reg_hi8   <= rg_hi;
        rm_is_reg <= is_reg;
        rm_reg    <= rmreg_n;
        rm_hi8    <= rm_hi;
        has_sib   <= use_sib;
        base_num  <= base_n;
        index_num <= index_n;
        scale_mul <= scale_n;
        disp      <= disp_n;
        no_base   <= nob_n;
        no_index  <= noix_n;
        rip_rel   <= rip;
      end
    end
  end

endmodule

// File: rtl/opaddr_decode_chk.sv
module opaddr_decode_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [7:0]  modrm,
  input logic        out_valid,
  input logic [3:0]  reg_num,
  input logic        reg_hi8,
  input logic        rm_is_reg,
  input logic        has_sib,
  input logic [3:0]  base_num,
  input logic [3:0]  index_num,
  input logic [3:0]  scale_mul,
  input logic [63:0] disp,
  input logic        no_base,
  input logic        no_index,
  input logic        rip_rel
);

  assert_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(disp) && $stable(base_num) && $stable(index_num) && $stable(reg_num));

  assert_regop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && rm_is_reg |-> no_base && no_index && !has_sib && disp == 64'd0);

  assert_rip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && rip_rel |-> no_base && !has_sib && !rm_is_reg);

  assert_scale_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(scale_mul) == 1);

  assert_noidx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && no_index |-> index_num == 4'd0);

  assert_d8_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && modrm[7:6] == 2'b01 |=> (&disp[63:7]) || !(|disp[63:7]));

  assert_hi8_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_hi8 |-> reg_num[3:2] == 2'b00);

endmodule

bind opaddr_decode opaddr_decode_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .modrm(modrm),
  .out_valid(out_valid), .reg_num(reg_num), .reg_hi8(reg_hi8),
  .rm_is_reg(rm_is_reg), .has_sib(has_sib), .base_num(base_num),
  .index_num(index_num), .scale_mul(scale_mul), .disp(disp),
  .no_base(no_base), .no_index(no_index), .rip_rel(rip_rel)
);

// File: tb/tb_opaddr_decode.sv
module tb_opaddr_decode;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic rex_present = 1'b0, rex_r = 1'b0, rex_x = 1'b0, rex_b = 1'b0, byte_op = 1'b0;
  logic [7:0] modrm = 8'd0, sib = 8'd0;
  logic [31:0] disp_in = 32'd0;
  logic out_valid, reg_hi8, rm_is_reg, rm_hi8, has_sib, no_base, no_index, rip_rel;
  logic [3:0] reg_num, rm_reg, base_num, index_num, scale_mul;
  logic [63:0] disp;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opaddr_decode dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .rex_present(rex_present),
    .rex_r(rex_r), .rex_x(rex_x), .rex_b(rex_b), .byte_op(byte_op),
    .modrm(modrm), .sib(sib), .disp_in(disp_in), .out_valid(out_valid),
    .reg_num(reg_num), .reg_hi8(reg_hi8), .rm_is_reg(rm_is_reg), .rm_reg(rm_reg),
    .rm_hi8(rm_hi8), .has_sib(has_sib), .base_num(base_num), .index_num(index_num),
    .scale_mul(scale_mul), .disp(disp), .no_base(no_base), .no_index(no_index),
    .rip_rel(rip_rel)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic rp, input logic r, input logic x, input logic b,
                       input logic bop, input logic [7:0] m, input logic [7:0] s,
                       input logic [31:0] d);
    @(negedge clk);
    rex_present = rp; rex_r = r; rex_x = x; rex_b = b; byte_op = bop;
    modrm = m; sib = s; disp_in = d; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R11 out_valid", {63'd0, out_valid}, 64'd0);
    chk("R11 disp", disp, 64'd0);
    chk("R11 base", {60'd0, base_num}, 64'd0);
    chk("R11 flags", {61'd0, no_base, no_index, rip_rel}, 64'd0);
  endtask

  task automatic t_regreg;
    issue(1, 1, 0, 1, 0, 8'b11_010_011, 8'hFF, 32'h1234_5678);
    chk("R1 out_valid", {63'd0, out_valid}, 64'd1);
    chk("R2 reg_num", {60'd0, reg_num}, 64'd10);
    chk("R3 rm_is_reg", {63'd0, rm_is_reg}, 64'd1);
    chk("R3 rm_reg", {60'd0, rm_reg}, 64'd11);
    chk("R3 flags", {61'd0, no_base, no_index, has_sib}, 64'b110);
    chk("R3 disp", disp, 64'd0);
    issue(0, 1, 1, 1, 0, 8'b11_010_011, 8'h00, 32'd0);
    chk("R2 rex absent reg", {60'd0, reg_num}, 64'd2);
    chk("R2 rex absent rm", {60'd0, rm_reg}, 64'd3);
  endtask

  task automatic t_disp;
    issue(0, 0, 0, 0, 0, 8'h43, 8'h00, 32'hAABB_CCF8);
    chk("R9 disp8 neg", disp, 64'hFFFF_FFFF_FFFF_FFF8);
    chk("R4 base", {60'd0, base_num}, 64'd3);
    chk("R4 flags", {60'd0, no_base, no_index, has_sib, rip_rel}, 64'b0100);
    chk("R4 scale", {60'd0, scale_mul}, 64'd1);
    issue(0, 0, 0, 0, 0, 8'h43, 8'h00, 32'hFFFF_FF08);
    chk("R9 disp8 pos", disp, 64'h8);
    issue(1, 0, 0, 1, 0, 8'b10_001_110, 8'h00, 32'h8000_1000);
    chk("R9 disp32 neg", disp, 64'hFFFF_FFFF_8000_1000);
    chk("R4 base ext", {60'd0, base_num}, 64'd14);
    issue(0, 0, 0, 0, 0, 8'b10_001_110, 8'h00, 32'h0000_1000);
    chk("R9 disp32 pos", disp, 64'h1000);
    issue(0, 0, 0, 0, 0, 8'h03, 8'h00, 32'hAABB_CCDD);
    chk("R9 mod00 none", disp, 64'd0);
  endtask

  task automatic t_rip;
    issue(1, 0, 0, 1, 0, 8'b00_011_101, 8'h00, 32'h0000_1234);
    chk("R5 rip", {61'd0, rip_rel, no_base, has_sib}, 64'b110);
    chk("R5 disp", disp, 64'h1234);
    issue(0, 0, 0, 0, 0, 8'b00_011_101, 8'h00, 32'hFFFF_FFF0);
    chk("R5 disp neg", disp, 64'hFFFF_FFFF_FFFF_FFF0);
  endtask

  task automatic t_sib;
    for (int s = 0; s < 4; s++) begin
      issue(0, 0, 0, 0, 0, 8'h04, {s[1:0], 3'b001, 3'b011}, 32'hFFFF_FFFF);
      chk("R6 scale", {60'd0, scale_mul}, 64'd1 << s);
      chk("R6 index", {60'd0, index_num}, 64'd1);
      chk("R6 base", {60'd0, base_num}, 64'd3);
      chk("R6 flags", {61'd0, has_sib, no_base, no_index}, 64'b100);
    end
    issue(1, 0, 1, 1, 0, 8'h44, 8'b11_010_000, 32'h0000_0010);
    chk("R6 ext index", {60'd0, index_num}, 64'd10);
    chk("R6 ext base", {60'd0, base_num}, 64'd8);
    chk("R9 sib disp8", disp, 64'h10);
  endtask

  task automatic t_noindex;
    issue(0, 0, 0, 0, 0, 8'h04, 8'b10_100_011, 32'd0);
    chk("R7 no index", {63'd0, no_index}, 64'd1);
    chk("R7 index zero", {60'd0, index_num}, 64'd0);
    issue(1, 0, 1, 0, 0, 8'h04, 8'b10_100_011, 32'd0);
    chk("R7 r12 index", {63'd0, no_index}, 64'd0);
    chk("R7 r12 num", {60'd0, index_num}, 64'd12);
  endtask

  task automatic t_nobase;
    issue(1, 0, 0, 1, 0, 8'h04, 8'b00_001_101, 32'h8765_4321);
    chk("R8 no base", {63'd0, no_base}, 64'd1);
    chk("R8 base zero", {60'd0, base_num}, 64'd0);
    chk("R8 disp32", disp, 64'hFFFF_FFFF_8765_4321);
    issue(1, 0, 0, 1, 0, 8'h44, 8'b00_001_101, 32'h0000_0020);
    chk("R8 mod01 base", {60'd0, base_num}, 64'd13);
    chk("R8 mod01 flag", {63'd0, no_base}, 64'd0);
    issue(0, 0, 0, 0, 0, 8'h84, 8'b00_001_101, 32'h0000_0020);
    chk("R8 mod10 base", {60'd0, base_num}, 64'd5);
  endtask

  task automatic t_byte;
    issue(0, 0, 0, 0, 1, 8'b11_100_101, 8'h00, 32'd0);
    chk("R10 reg hi8", {59'd0, reg_hi8, reg_num}, {59'd0, 1'b1, 4'd0});
    chk("R10 rm hi8", {59'd0, rm_hi8, rm_reg}, {59'd0, 1'b1, 4'd1});
    issue(1, 0, 0, 0, 1, 8'b11_100_101, 8'h00, 32'd0);
    chk("R10 rex reg", {59'd0, reg_hi8, reg_num}, {59'd0, 1'b0, 4'd4});
    chk("R10 rex rm", {59'd0, rm_hi8, rm_reg}, {59'd0, 1'b0, 4'd5});
    issue(0, 0, 0, 0, 0, 8'b11_100_101, 8'h00, 32'd0);
    chk("R10 wide reg", {59'd0, reg_hi8, reg_num}, {59'd0, 1'b0, 4'd4});
  endtask

  task automatic t_hold;
    issue(1, 1, 1, 1, 0, 8'h84, 8'b01_011_010, 32'h0000_0100);
    chk("R1 pulse", {63'd0, out_valid}, 64'd1);
    @(negedge clk);
    modrm = 8'hC0; sib = 8'h00; disp_in = 32'hDEAD_BEEF; rex_present = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 low after", {63'd0, out_valid}, 64'd0);
    chk("R1 hold disp", disp, 64'h100);
    chk("R1 hold base", {60'd0, base_num}, 64'd10);
    chk("R1 hold index", {60'd0, index_num}, 64'd11);
    chk("R1 hold reg", {60'd0, reg_num}, 64'd8);
    chk("R1 hold scale", {60'd0, scale_mul}, 64'd2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_regreg;
    t_disp;
    t_rip;
    t_sib;
    t_noindex;
    t_nobase;
    t_byte;
    t_hold;
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule